// File: doc/BRIEF.md
# Triggered Event Memory with Roll and Noisy-Window Guard

This block stores triggered events for a multi-channel front-end during an acquisition window. Each accepted trigger writes one record made of the bunch-crossing number and the channel hit mask, so later readout logic only sees channels that fired. A trigger that arrives with no channel hit leaves no record, which keeps empty triggers out of the memory.

Storage follows one of two policies, chosen by a mode input. In the fill-then-stop policy the first `DEPTH` records are kept and later triggers are dropped. In the circular policy the newest `DEPTH` records are kept and each new record overwrites the oldest one. A guard counts every trigger taken inside the window. When the count reaches `NOISY_LIMIT`, the window is declared noisy, all records are discarded, and nothing more is stored until the next window opens. The readout logic reads records by logical index, where index 0 is always the oldest record held.

A small state machine sets the window behaviour. The states are IDLE (no window open), ACQ (window open, storing) and NOISY (window open, storage blocked). The transitions are:
- OPEN: any state to ACQ on `win_start`.
- CLOSE: ACQ or NOISY to IDLE on `win_end`.
- FLOOD: ACQ to NOISY on the trigger that brings the window count to `NOISY_LIMIT`.

`win_start` takes priority over `win_end`, and both take priority over a trigger in the same cycle.

Top module: `event_store`

## Requirements
- R1: With `roll_mode`=0, the first `DEPTH` records of a window are kept and later triggers are ignored. `full` is 1 exactly when `roll_mode`=0 and `evt_count`=`DEPTH`.
- R2: With `roll_mode`=1, the newest `DEPTH` records are kept and a new record replaces the oldest one. `full` stays 0 in this mode.
- R3: `rd_idx`=0 addresses the oldest record held, and higher indices address newer records. `rd_valid` is 1 only when `rd_idx` < `evt_count`. While `rd_valid` is 0, `rd_bcid` and `rd_hits` read as zero.
- R4: A record holds the `bcid` and the exact `hits` mask sampled at the trigger edge. A trigger whose `hits` is all zero writes no record.
- R5: `evt_count` rises by one for each stored record and saturates at `DEPTH`.
- R6: The `NOISY_LIMIT`-th trigger taken in a window causes the following, with empty-hit triggers included in the count:
  - `noisy` is set to 1;
  - `evt_count` is cleared to 0;
  - later triggers are ignored until the next `win_start`.
- R7: `win_start` causes the following:
  - the window opens in the cycle after it;
  - `evt_count`, the write position, the trigger count and `noisy` are cleared;
  - a trigger in the same cycle is not stored and not counted.
- R8: Outside a window (after reset or after `win_end`), triggers are ignored and the records already stored stay readable.
- R9: After reset, `evt_count`=0, `full`=0, `noisy`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_start | input | 1 | Pulse that opens and clears an acquisition window |
| win_end | input | 1 | Pulse that closes the window |
| roll_mode | input | 1 | 0 = keep first records, 1 = keep newest records |
| trig | input | 1 | Trigger strobe |
| hits | input | NCH | Channel hit mask at the trigger |
| bcid | input | BCW | Bunch-crossing number at the trigger |
| rd_idx | input | AW | Logical read index, 0 = oldest |
| rd_valid | output | 1 | The read index addresses a held record |
| rd_bcid | output | BCW | Bunch-crossing number of the addressed record |
| rd_hits | output | NCH | Hit mask of the addressed record |
| evt_count | output | CW | Number of records held |
| full | output | 1 | Fill-then-stop memory has reached DEPTH |
| noisy | output | 1 | The current window was declared noisy |

## Verification
The bench builds the block with `DEPTH`=5, `NCH`=8, `BCW`=8 and `NOISY_LIMIT`=12.

A depth of 5 is not a power of two. This forces the read path to use its compare-and-subtract wrap instead of plain truncation. With only 5 slots, overwrites in the circular mode and the dropped triggers in the fill-then-stop mode happen within a few cycles.

A limit of 12 is above the depth, so one window can fill, wrap and then flood. That lets a single trace cover R1, R2 and R6 together. Randomised windows also switch the mode between windows and mix in empty-hit triggers and same-cycle start/trigger collisions.

// File: rtl/evm_pkg.sv
package evm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACQ   = 2'd1,
        ST_NOISY = 2'd2
    } evm_state_e;
endpackage

// File: rtl/evm_ctrl.sv
module evm_ctrl #(
    parameter int NOISY_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic win_start,
    input  logic win_end,
    input  logic trig,
    output logic clr,
    output logic wr_try,
    output logic noisy
);
    import evm_pkg::*;

    localparam int TW = (NOISY_LIMIT > 2) ? $clog2(NOISY_LIMIT) : 1;
    localparam logic [TW-1:0] TLAST = TW'(NOISY_LIMIT - 1);

    evm_state_e st_q, st_d;
    logic [TW-1:0] tcnt_q;
    logic take_trig, flood;

    // trigger qualification: window open, no control pulse this cycle
    always_comb begin
        take_trig = (st_q == ST_ACQ) && trig && !win_start && !win_end;
        flood     = take_trig && (tcnt_q == TLAST);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (win_start) st_d = ST_ACQ;          // OPEN
            end
            ST_ACQ: begin
                if (win_start)    st_d = ST_ACQ;       // OPEN
                else if (win_end) st_d = ST_IDLE;      // CLOSE
                else if (flood)   st_d = ST_NOISY;     // FLOOD
            end
            ST_NOISY: begin
                if (win_start)    st_d = ST_ACQ;       // OPEN
                else if (win_end) st_d = ST_IDLE;      // CLOSE
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // window trigger counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  tcnt_q <= '0;
        else if (win_start)          tcnt_q <= '0;
        else if (take_trig && !flood) tcnt_q <= tcnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        clr    = win_start || flood;
        wr_try = take_trig && !flood;
        noisy  = (st_q == ST_NOISY);
    end
endmodule

// File: rtl/evm_wptr.sv
module evm_wptr #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_try,
    input  logic          hit_any,
    input  logic          roll_mode,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] oldest,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CFULL = CW'(DEPTH);
    localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);

    logic [AW-1:0] wptr_q;
    logic [CW-1:0] cnt_q;
    logic          at_depth;

    always_comb begin
        at_depth = (cnt_q == CFULL);
        we       = wr_try && hit_any && (roll_mode || !at_depth);
        waddr    = wptr_q;
        oldest   = at_depth ? wptr_q : '0;
        count    = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (we) begin
            wptr_q <= (wptr_q == ALAST) ? '0 : wptr_q + 1'b1;
            if (!at_depth) cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/evm_store.sv
module evm_store #(
    parameter int DEPTH = 8,
    parameter int NCH   = 16,
    parameter int BCW   = 12,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [BCW-1:0] wbcid,
    input  logic [NCH-1:0] whits,
    input  logic [AW-1:0]  oldest,
    input  logic [CW-1:0]  count,
    input  logic [AW-1:0]  rd_idx,
    output logic           rd_valid,
    output logic [BCW-1:0] rd_bcid,
    output logic [NCH-1:0] rd_hits
);
    localparam bit POW2 = (DEPTH == (1 << AW));

    logic [DEPTH-1:0][BCW-1:0] bc_q;
    logic [DEPTH-1:0][NCH-1:0] hm_q;
    logic [AW-1:0] phys;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_q <= '0;
            hm_q <= '0;
        end else if (we) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (waddr == AW'(i)) begin
                    bc_q[i] <= wbcid;
                    hm_q[i] <= whits;
                end
            end
        end
    end

    // logical-to-physical address: modulo DEPTH
    generate
        if (POW2) begin : g_wrap_pow2
            always_comb phys = oldest + rd_idx;
        end else begin : g_wrap_mod
            logic [AW:0] sum;
            always_comb begin
                sum = {1'b0, oldest} + {1'b0, rd_idx};
                if (sum >= (AW+1)'(DEPTH)) sum = sum - (AW+1)'(DEPTH);
                phys = sum[AW-1:0];
            end
        end
    endgenerate

    always_comb begin
        rd_valid = (CW'(rd_idx) < count);
        rd_bcid  = '0;
        rd_hits  = '0;
        if (rd_valid) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (phys == AW'(i)) begin
                    rd_bcid = bc_q[i];
                    rd_hits = hm_q[i];
                end
            end
        end
    end
endmodule

// File: rtl/event_store.sv
module event_store #(
    parameter int DEPTH       = 8,
    parameter int NCH         = 16,
    parameter int BCW         = 12,
    parameter int NOISY_LIMIT = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           win_start,
    input  logic           win_end,
    input  logic           roll_mode,
    input  logic           trig,
    input  logic [NCH-1:0] hits,
    input  logic [BCW-1:0] bcid,
    input  logic [AW-1:0]  rd_idx,
    output logic           rd_valid,
    output logic [BCW-1:0] rd_bcid,
    output logic [NCH-1:0] rd_hits,
    output logic [CW-1:0]  evt_count,
    output logic           full,
    output logic           noisy
);
    logic clr, wr_try, we;
    logic [AW-1:0] waddr, oldest;

    evm_ctrl #(.NOISY_LIMIT(NOISY_LIMIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
        .trig(trig), .clr(clr), .wr_try(wr_try), .noisy(noisy)
    );

    evm_wptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_try(wr_try),
        .hit_any(|hits), .roll_mode(roll_mode), .we(we), .waddr(waddr),
        .oldest(oldest), .count(evt_count)
    );

    evm_store #(.DEPTH(DEPTH), .NCH(NCH), .BCW(BCW), .AW(AW), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wbcid(bcid),
        .whits(hits), .oldest(oldest), .count(evt_count), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_bcid(rd_bcid), .rd_hits(rd_hits)
    );

    always_comb full = !roll_mode && (evt_count == CW'(DEPTH));
endmodule

// File: rtl/event_store_chk.sv
module event_store_chk #(
    parameter int DEPTH = 8,
    parameter int NCH   = 16,
    parameter int BCW   = 12,
    parameter int AW    = 3,
    parameter int CW    = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           win_start,
    input logic           roll_mode,
    input logic           trig,
    input logic [NCH-1:0] hits,
    input logic [AW-1:0]  rd_idx,
    input logic           rd_valid,
    input logic [BCW-1:0] rd_bcid,
    input logic [NCH-1:0] rd_hits,
    input logic [CW-1:0]  evt_count,
    input logic           full,
    input logic           noisy
);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(evt_count) <= DEPTH);

    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int'(evt_count) <= int'($past(evt_count)) + 1);

    a_r1_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !win_start) |=> (int'(evt_count) == DEPTH) || noisy);

    a_r2_roll_never_full: assert property (@(posedge clk) disable iff (!rst_n)
        roll_mode |-> !full);

    a_r3_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> int'(rd_idx) < int'(evt_count));

    a_r3_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_bcid == '0) && (rd_hits == '0));

    a_r4_empty_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && hits == '0) |=> evt_count <= $past(evt_count));

    a_r6_noisy_empty: assert property (@(posedge clk) disable iff (!rst_n)
        noisy |-> evt_count == '0);

    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        win_start |=> (evt_count == '0) && !noisy);
endmodule

bind event_store event_store_chk #(
    .DEPTH(DEPTH), .NCH(NCH), .BCW(BCW), .AW(AW), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .win_start(win_start), .roll_mode(roll_mode),
    .trig(trig), .hits(hits), .rd_idx(rd_idx), .rd_valid(rd_valid),
    .rd_bcid(rd_bcid), .rd_hits(rd_hits), .evt_count(evt_count),
    .full(full), .noisy(noisy)
);

// File: tb/sim_event_store.sv
`timescale 1ns/1ps
module sim_event_store;
    localparam int DEPTH = 5;
    localparam int NCH   = 8;
    localparam int BCW   = 8;
    localparam int LIM   = 12;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic win_start = 0, win_end = 0, roll_mode = 0, trig = 0;
    logic [NCH-1:0] hits = '0;
    logic [BCW-1:0] bcid = '0;
    logic [AW-1:0]  rd_idx = '0;
    logic rd_valid, full, noisy;
    logic [BCW-1:0] rd_bcid;
    logic [NCH-1:0] rd_hits;
    logic [CW-1:0]  evt_count;

    int n_checks = 0, n_fail = 0, sweep = 0;
    logic [BCW+NCH-1:0] q[$];
    int m_st = 0, m_tc = 0;

    always #4 clk = ~clk;   // 125 MHz

    event_store #(.DEPTH(DEPTH), .NCH(NCH), .BCW(BCW), .NOISY_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .win_start(win_start), .win_end(win_end),
        .roll_mode(roll_mode), .trig(trig), .hits(hits), .bcid(bcid),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_bcid(rd_bcid),
        .rd_hits(rd_hits), .evt_count(evt_count), .full(full), .noisy(noisy)
    );

    // behavioural reference: queue of records, window state, trigger tally
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_st = 0; m_tc = 0;
        end else if (win_start) begin
            q.delete(); m_tc = 0; m_st = 1;
        end else if (win_end) begin
            m_st = 0;
        end else if (m_st == 1 && trig) begin
            m_tc++;
            if (m_tc == LIM) begin
                m_st = 2; q.delete();
            end else if (hits != '0) begin
                if (roll_mode) begin
                    if (q.size() == DEPTH) void'(q.pop_front());
                    q.push_back({bcid, hits});
                end else if (q.size() < DEPTH) begin
                    q.push_back({bcid, hits});
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int idx;
        idx = int'(rd_idx);
        chk("R5 count", int'(evt_count), q.size());
        chk("R1 full", int'(full), int'(!roll_mode && q.size() == DEPTH));
        chk("R6 noisy", int'(noisy), int'(m_st == 2));
        chk("R3 valid", int'(rd_valid), int'(idx < q.size()));
        if (idx < q.size()) begin
            chk("R4 bcid", int'(rd_bcid), int'(q[idx][BCW+NCH-1:NCH]));
            chk("R4 hits", int'(rd_hits), int'(q[idx][NCH-1:0]));
        end
    endtask

    task automatic step(input logic ws, input logic we_, input logic tr,
                        input logic [NCH-1:0] h, input logic [BCW-1:0] b);
        win_start = ws; win_end = we_; trig = tr; hits = h; bcid = b;
        rd_idx = AW'(sweep % DEPTH); sweep++;
        @(posedge clk); #2;
        compare();
        @(negedge clk);
    endtask

    task automatic peek(input int idx);
        win_start = 0; win_end = 0; trig = 0;
        rd_idx = AW'(idx); #1;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        peek(0);
        chk("R9 count", int'(evt_count), 0);
        chk("R9 full", int'(full), 0);
        chk("R9 noisy", int'(noisy), 0);
        chk("R9 valid", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: no window open yet
        step(0, 0, 1, 8'h03, 8'h01);
        step(0, 0, 1, 8'h05, 8'h02);
        peek(0);
        chk("R8 idle trig", int'(evt_count), 0);

        // R1/R4: fill-then-stop, one empty trigger
        roll_mode = 0;
        step(1, 0, 0, '0, '0);
        for (int i = 0; i < 7; i++)
            step(0, 0, 1, (i == 2) ? 8'h00 : 8'h01 << i, 8'h10 + 8'(i));
        peek(0); chk("R1 oldest", int'(rd_bcid), 'h10);
        peek(2); chk("R4 skip empty", int'(rd_bcid), 'h13);
        chk("R4 mask", int'(rd_hits), 'h08);
        peek(4); chk("R1 last kept", int'(rd_bcid), 'h15);
        chk("R1 full", int'(full), 1);
        chk("R5 saturate", int'(evt_count), 5);

        // R8: closed window keeps data
        step(0, 1, 0, '0, '0);
        step(0, 0, 1, 8'hFF, 8'h77);
        peek(0); chk("R8 retained", int'(rd_bcid), 'h10);
        chk("R8 count", int'(evt_count), 5);

        // R2: circular keeps newest
        roll_mode = 1;
        step(1, 0, 0, '0, '0);
        for (int i = 0; i < 8; i++) step(0, 0, 1, 8'h80 | 8'(i), 8'h20 + 8'(i));
        peek(0); chk("R2 oldest", int'(rd_bcid), 'h23);
        peek(4); chk("R2 newest", int'(rd_bcid), 'h27);
        chk("R2 full", int'(full), 0);

        // R6: 12th trigger of the window floods
        for (int i = 8; i < 12; i++) step(0, 0, 1, 8'h40, 8'h20 + 8'(i));
        peek(0);
        chk("R6 noisy", int'(noisy), 1);
        chk("R6 dropped", int'(evt_count), 0);
        step(0, 0, 1, 8'h01, 8'h55);
        peek(0); chk("R6 blocked", int'(evt_count), 0);

        // R7: start with trigger in the same cycle
        step(1, 0, 1, 8'h01, 8'h66);
        peek(0);
        chk("R7 noisy clear", int'(noisy), 0);
        chk("R7 trig ignored", int'(evt_count), 0);

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 3) roll_mode = ~roll_mode;
            step(r < 6, (r >= 6 && r < 9), r > 40,
                 (r > 80) ? 8'h00 : 8'($urandom), 8'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule